// File: doc/BRIEF.md
# Fault-Aware Mesh Route Computation

This unit chooses the output port for packets passing through one router of a two-dimensional mesh network-on-chip. When a head flit arrives it compares the router's own coordinates with the packet's destination and selects north, south, east, west or local. Each packet carries an order bit, and the unit honours it. With the bit clear, X is resolved before Y. With the bit set, Y is resolved before X. Running both orders across the traffic spreads load over the mesh.

A small table holds one entry per destination, and a configuration write port fills it. A valid entry names a port that is known to reach that destination around broken links, and that port replaces the dimension-order choice. A four-bit link-down mask marks faulty neighbour links. If the dimension-order result points at a faulty link and the table has no valid entry for the destination, the unit flags the packet as unroutable and does not send it into the fault. Flow control is wormhole. Only head flits are routed, and every later flit reuses the port latched for its packet.

Top module: `mesh_route_unit`

## Requirements
- R1: After reset, route_valid is 0 and every table entry is invalid.
- R2: With order_yx = 0 the port is east (code 2) if dest_x > here_x, west (4) if dest_x < here_x, otherwise north (1) if dest_y > here_y, south (3) if dest_y < here_y.
- R3: With order_yx = 1 the Y comparison decides first (north 1 / south 3), and east 2 / west 4 applies only when the rows match.
- R4: A head flit whose destination equals here_x/here_y gets port 0 (local) with route_blocked = 0, whatever the table holds.
- R5: A table entry with bit 3 set and a port code 0..4 in bits 2:0 replaces the dimension-order port, and link_down has no effect on it. The entry for destination (x,y) sits at address y*X_DIM + x.
- R6: An entry with bit 3 clear, or with a port code of 5..7, is ignored, and dimension order applies.
- R7: A table write takes effect from the next cycle. A head flit presented in the same cycle as the write sees the old contents.
- R8: link_down bits 0..3 mark north, east, south and west. When no table entry applies and the dimension-order port is marked down, the result is route_blocked = 1 with route_port = 0.
- R9: A flit with flit_head = 0 receives the port and blocked flag latched by the most recent head flit, and its destination fields are ignored.
- R10: route_valid, route_port and route_blocked are registered and appear one cycle after the flit is presented. route_valid is 0 in any cycle that follows a cycle with no flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | A flit is presented this cycle |
| flit_head | input | 1 | The presented flit is a head flit |
| here_x | input | XW | This router's column |
| here_y | input | YW | This router's row |
| dest_x | input | XW | Destination column |
| dest_y | input | YW | Destination row |
| order_yx | input | 1 | 0: X-first order, 1: Y-first order |
| link_down | input | 4 | Faulty link mask: bit 0 N, 1 E, 2 S, 3 W |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | AW | Table write address (y*X_DIM + x) |
| cfg_entry | input | 4 | Entry: bit 3 valid, bits 2:0 port code |
| route_valid | output | 1 | Route result valid |
| route_port | output | 3 | Port code: 0 local, 1 N, 2 E, 3 S, 4 W |
| route_blocked | output | 1 | No safe port is known for this packet |

## Verification
Every routing result is due exactly one clock edge after the flit that caused it. The bench drives each flit on a falling edge and reads the outputs on the next falling edge, which is the only cycle where the result belongs to that flit. A table write takes effect at the edge where it is captured, so the bench presents a head flit in the write cycle to see the old route, and another one a cycle later to see the new route. Body flits are sent back to back behind their head, so the held port is checked on consecutive cycles, and an idle cycle shows route_valid low.

// File: rtl/mesh_route_unit.sv
module mesh_route_unit #(
  parameter int X_DIM = 4,
  parameter int Y_DIM = 4,
  localparam int XW = (X_DIM > 1) ? $clog2(X_DIM) : 1,
  localparam int YW = (Y_DIM > 1) ? $clog2(Y_DIM) : 1,
  localparam int N  = X_DIM * Y_DIM,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flit_valid,
  input  logic          flit_head,
  input  logic [XW-1:0] here_x,
  input  logic [YW-1:0] here_y,
  input  logic [XW-1:0] dest_x,
  input  logic [YW-1:0] dest_y,
  input  logic          order_yx,
  input  logic [3:0]    link_down,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [3:0]    cfg_entry,
  output logic          route_valid,
  output logic [2:0]    route_port,
  output logic          route_blocked
);
  logic [3:0]    tbl [N];
  logic [2:0]    held_port;
  logic          held_blk;
  logic [AW-1:0] rd_addr;
  logic [3:0]    entry;
  logic [2:0]    x_dir, y_dir, dor, head_port;
  logic          at_home, hit, dor_down, head_blk;

  assign at_home = (dest_x == here_x) && (dest_y == here_y);
  assign rd_addr = AW'(dest_y) * AW'(X_DIM) + AW'(dest_x);
  assign entry   = (int'(rd_addr) < N) ? tbl[rd_addr] : 4'd0;
  assign hit     = entry[3] && (entry[2:0] <= 3'd4);

  assign x_dir = (dest_x > here_x) ? 3'd2 : (dest_x < here_x) ? 3'd4 : 3'd0;
  assign y_dir = (dest_y > here_y) ? 3'd1 : (dest_y < here_y) ? 3'd3 : 3'd0;
  assign dor   = order_yx ? ((y_dir != 3'd0) ? y_dir : x_dir)
                          : ((x_dir != 3'd0) ? x_dir : y_dir);

  always_comb begin
    case (dor)
      3'd1:    dor_down = link_down[0];
      3'd2:    dor_down = link_down[1];
      3'd3:    dor_down = link_down[2];
      3'd4:    dor_down = link_down[3];
      default: dor_down = 1'b0;
    endcase
  end

  always_comb begin
    head_port = dor;
    head_blk  = 1'b0;
    if (at_home) begin
      head_port = 3'd0;
    end else if (hit) begin
      head_port = entry[2:0];
    end else if (dor_down) begin
      head_port = 3'd0;
      head_blk  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl[i] <= 4'd0;
    end else if (cfg_we && int'(cfg_addr) < N) begin
      tbl[cfg_addr] <= cfg_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_valid   <= 1'b0;
      route_port    <= 3'd0;
      route_blocked <= 1'b0;
      held_port     <= 3'd0;
      held_blk      <= 1'b0;
    end else begin
      route_valid <= flit_valid;
      if (flit_valid && flit_head) begin
        held_port     <= head_port;
        held_blk      <= head_blk;
        route_port    <= head_port;
        route_blocked <= head_blk;
      end else if (flit_valid) begin
        route_port    <= held_port;
        route_blocked <= held_blk;
      end
    end
  end
endmodule

module mesh_route_unit_chk #(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flit_valid,
  input logic          flit_head,
  input logic [XW-1:0] here_x,
  input logic [YW-1:0] here_y,
  input logic [XW-1:0] dest_x,
  input logic [YW-1:0] dest_y,
  input logic          route_valid,
  input logic [2:0]    route_port,
  input logic          route_blocked
);
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |=> route_valid);
  p_idle_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flit_valid |=> !route_valid);
  p_home_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && flit_head && dest_x == here_x && dest_y == here_y)
    |=> (route_port == 3'd0 && !route_blocked));
  p_blocked_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    route_blocked |-> route_port == 3'd0);
  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> route_port <= 3'd4);
  p_body_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && flit_valid && !flit_head)
    |=> (route_port == $past(route_port) && route_blocked == $past(route_blocked)));
endmodule

bind mesh_route_unit mesh_route_unit_chk #(.XW(XW), .YW(YW)) u_chk (.*);

// File: tb/mesh_route_unit_test.sv
module mesh_route_unit_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       flit_valid = 0, flit_head = 0, order_yx = 0, cfg_we = 0;
  logic [1:0] here_x = 2'd1, here_y = 2'd2, dest_x = 0, dest_y = 0;
  logic [3:0] link_down = 0, cfg_addr = 0, cfg_entry = 0;
  logic       route_valid, route_blocked;
  logic [2:0] route_port;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  mesh_route_unit uut (.*);

  task automatic chk(string rq, int got, int exp);
    runs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  task automatic route(string rq, bit head, int dx, int dy, bit yx, int ep, int eb);
    @(negedge clk);
    flit_valid = 1; flit_head = head; dest_x = 2'(dx); dest_y = 2'(dy); order_yx = yx;
    @(negedge clk);
    chk({rq, " valid"}, route_valid, 1);
    chk({rq, " port"}, route_port, ep);
    chk({rq, " blocked"}, route_blocked, eb);
    flit_valid = 0; flit_head = 0;
  endtask

  task automatic wr(int a, int e);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_entry = 4'(e);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", route_valid, 0);
    link_down = 4'hF;
    route("R1 table empty", 1, 3, 2, 0, 0, 1);
    link_down = 0;
  endtask

  task automatic t_xy;
    route("R2 east", 1, 3, 0, 0, 2, 0);
    route("R2 west", 1, 0, 3, 0, 4, 0);
    route("R2 south", 1, 1, 0, 0, 3, 0);
    route("R2 north", 1, 1, 3, 0, 1, 0);
  endtask

  task automatic t_yx;
    route("R3 south", 1, 3, 0, 1, 3, 0);
    route("R3 north", 1, 0, 3, 1, 1, 0);
    route("R3 east", 1, 3, 2, 1, 2, 0);
  endtask

  task automatic t_local;
    wr(9, 4'hA);
    route("R4 local", 1, 1, 2, 0, 0, 0);
  endtask

  task automatic t_table;
    wr(3, 4'hC);
    link_down = 4'hF;
    route("R5 override", 1, 3, 0, 0, 4, 0);
    link_down = 0;
    wr(12, 4'h1);
    route("R6 invalid entry", 1, 0, 3, 0, 4, 0);
    wr(15, 4'hE);
    route("R6 bad code", 1, 3, 3, 0, 2, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'd2; cfg_entry = 4'h9;
    flit_valid = 1; flit_head = 1; dest_x = 2'd2; dest_y = 2'd0; order_yx = 0;
    @(negedge clk);
    cfg_we = 0;
    chk("R7 old contents", route_port, 2);
    @(negedge clk);
    chk("R7 new contents", route_port, 1);
    flit_valid = 0; flit_head = 0;
  endtask

  task automatic t_mask;
    link_down = 4'b0010;
    route("R8 east down", 1, 3, 2, 0, 0, 1);
    link_down = 4'b0001;
    route("R8 north down", 1, 2, 3, 1, 0, 1);
    link_down = 0;
  endtask

  task automatic t_body;
    @(negedge clk);
    flit_valid = 1; flit_head = 1; dest_x = 2'd3; dest_y = 2'd2; order_yx = 0;
    @(negedge clk);
    chk("R9 head port", route_port, 2);
    flit_head = 0; dest_x = 2'd0;
    @(negedge clk);
    chk("R9 body port", route_port, 2);
    @(negedge clk);
    chk("R9 second body", route_port, 2);
    flit_valid = 0;
    @(negedge clk);
    chk("R10 idle valid", route_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_xy;
    t_yx;
    t_local;
    t_table;
    t_timing;
    t_mask;
    t_body;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #160000;
    runs++; fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule